// File: doc/BRIEF.md
# Sequential Triangular-Sum Unit

This block adds up every integer from a small unsigned input `n_in` down to one. It takes several clock cycles to do so. A six-state Moore controller drives four strobes into a datapath: load, count, clear and sumload. The datapath holds a loadable down-counter and an accumulator register. On each pass of the loop, the accumulator adds the current counter value, zero-extended to its own width, and then the counter steps down by one. The loop ends when the counter's zero flag is seen, and `done` then rises for a single cycle.

The caller holds `n_in` stable and gives a one-cycle `start` pulse while the unit is idle. It then waits for `done`, and reads `sum_out` in that cycle or in the cycle after it. While idle, the controller keeps the accumulator cleared, so the result is removed two cycles after `done`. The counter value and the load strobe are brought out so that the progress of a run can be observed.

Top module: `tsum_top`

## Requirements
- R1: While `rst_n` is 0, the controller is held in idle and the counter and accumulator are held at 0, without waiting for a clock edge. So `sum_out`, `cval`, `load_out` and `done` are all 0.
- R2: In idle (state 000) the clear strobe is asserted. The unit stays idle while `start` is 0, and `sum_out` stays 0.
- R3: The down-counter takes `n_in` when load is 1. Otherwise it decrements when count is 1, and otherwise it holds. Load wins over count. `cval` equals `n_in` two cycles after `start` is sampled.
- R4: The counter's zero flag is 1 exactly when the counter value is 0. Seeing this flag in the test state ends the loop. With `n_in` = 0 the sum is 0, and `cval` is 0 whenever `done` is high.
- R5: The accumulator clears when clear is 1, and clear takes priority over sumload. Otherwise, when sumload is 1, it adds the counter value padded with high zero bits to its contents.
- R6: When `done` is high, `sum_out` equals n(n+1)/2 for every `n_in` from 0 to 15. This gives 120 for 15.
- R7: `done` is high for exactly one cycle per start. It first appears 3n+3 clock edges after the edge that samples `start`.
- R8: The strobes are decoded from the state alone, and at most one of them is high at a time. `load_out` is high for exactly the one cycle after `start` is sampled.
- R9: `sum_out` keeps its final value in the cycle after `done`. It is 0 one cycle later, because idle clears it.
- R10: A `start` pulse that arrives while a run is in progress has no effect on that run's result or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled only while idle |
| n_in | input | CNT_W (4) | Upper bound of the sum |
| sum_out | output | ACC_W (8) | Accumulator contents |
| cval | output | CNT_W (4) | Current down-counter value |
| load_out | output | 1 | Controller load strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
Count the rising edge that samples `start` as edge 1. `load_out` is due after that edge, and `cval` shows `n_in` after edge 2. `done` with the final sum is due after edge 3n+3. The sum is still present one edge later, and it is zero after the edge that follows. The bench drives on falling edges and counts falling edges from the start pulse. Each value is compared at the falling edge whose count matches its due edge, so a result that arrives one cycle early or late fails.

// File: rtl/tsum_pkg.sv
package tsum_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_LOAD = 3'b001,
    ST_TEST = 3'b010,
    ST_ADD  = 3'b011,
    ST_DEC  = 3'b100,
    ST_DONE = 3'b101
  } tsum_state_e;

  typedef struct packed {
    logic load;
    logic count;
    logic clear;
    logic sumload;
    logic done;
  } tsum_strobe_t;
endpackage

// File: rtl/tsum_counter.sv
module tsum_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         count,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= d;
    else if (count) q <= q - 1'b1;
  end

  assign zero = (q == '0);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d)); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count) |=> q == W'($past(q) - 1'b1)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !count) |=> $stable(q)); // R3
endmodule

// File: rtl/tsum_accum.sv
module tsum_accum #(
  parameter int CW = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          we,
  input  logic [CW-1:0] addend,
  output logic [AW-1:0] q
);
  localparam int PAD_W = AW - CW;

  function automatic logic [AW-1:0] widen_add(input logic [AW-1:0] acc,
                                               input logic [CW-1:0] v);
    return acc + {{PAD_W{1'b0}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clear) q <= '0;
    else if (we)    q <= widen_add(q, addend);
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> q == '0); // R5
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && we) |=> (q - $past(q)) == AW'($past(addend))); // R5
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !we) |=> $stable(q)); // R5
endmodule

// File: rtl/tsum_ctrl.sv
module tsum_ctrl
  import tsum_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         zero,
  output tsum_strobe_t stb
);
  tsum_state_e state, state_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start) state_nx = ST_LOAD;
      ST_LOAD: state_nx = ST_TEST;
      ST_TEST: state_nx = zero ? ST_DONE : ST_ADD;
      ST_ADD:  state_nx = ST_DEC;
      ST_DEC:  state_nx = ST_TEST;
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE: stb.clear   = 1'b1;
      ST_LOAD: stb.load    = 1'b1;
      ST_ADD:  stb.sumload = 1'b1;
      ST_DEC:  stb.count   = 1'b1;
      ST_DONE: stb.done    = 1'b1;
      default: stb = '0;
    endcase
  end

  AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> state == ST_IDLE); // R2
  AST_ZERO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TEST && zero) |=> stb.done); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.done |=> !stb.done && stb.clear); // R7
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> !stb.load); // R8
endmodule

// File: rtl/tsum_top.sv
module tsum_top
  import tsum_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_in,
  output logic [ACC_W-1:0] sum_out,
  output logic [CNT_W-1:0] cval,
  output logic             load_out,
  output logic             done
);
  tsum_strobe_t     stb;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_q;

  tsum_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .zero  (cnt_zero),
    .stb   (stb)
  );

  tsum_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (stb.load),
    .count (stb.count),
    .d     (n_in),
    .q     (cnt_q),
    .zero  (cnt_zero)
  );

  tsum_accum #(.CW(CNT_W), .AW(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (stb.clear),
    .we     (stb.sumload),
    .addend (cnt_q),
    .q      (sum_out)
  );

  assign cval     = cnt_q;
  assign load_out = stb.load;
  assign done     = stb.done;

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cval == '0); // R4
  AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(sum_out)); // R9
endmodule

// File: tb/test_tsum_top.sv
module test_tsum_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] n_in = '0;
  logic [7:0] sum_out;
  logic [3:0] cval;
  logic       load_out;
  logic       done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  tsum_top i_tsum_top (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
    .sum_out(sum_out), .cval(cval), .load_out(load_out), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run(input int n, input bit poke);
    int k;
    int expect_sum;
    int expect_lat;
    expect_sum = n * (n + 1) / 2;
    expect_lat = 3 * n + 3;
    @(negedge clk);
    n_in  = 4'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 load_out after start", int'(load_out), 1);
    k = 1;
    while (1) begin
      @(negedge clk);
      k++;
      if (k == 2) begin
        check("R3 cval loaded", int'(cval), n);
        check("R8 load_out single", int'(load_out), 0);
      end
      if (poke && k == 4) start = 1'b1;
      if (poke && k == 5) start = 1'b0;
      if (done || k > 80) break;
    end
    check("R7 done latency", k, expect_lat);
    check("R6 sum at done", int'(sum_out), expect_sum);
    check("R4 cval zero at done", int'(cval), 0);
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
    check("R9 sum kept", int'(sum_out), expect_sum);
    @(negedge clk);
    check("R9 sum cleared", int'(sum_out), 0);
  endtask

  initial begin
    #5;
    check("R1 sum in reset", int'(sum_out), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 load in reset", int'(load_out), 0);
    check("R1 cval in reset", int'(cval), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: idle without start
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R2 idle sum", int'(sum_out), 0);
      check("R2 idle done", int'(done), 0);
      check("R2 idle load", int'(load_out), 0);
    end
    // R6 / R4 / R3 / R5: full sweep
    for (int n = 0; n < 16; n++) run(n, 1'b0);
    // R10: start during a run has no effect
    run(7, 1'b1);
    run(15, 1'b1);
    run(1, 1'b1);
    // R1: asynchronous reset mid-run
    @(negedge clk);
    n_in  = 4'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 8; i++) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async sum", int'(sum_out), 0);
    check("R1 async cval", int'(cval), 0);
    check("R1 async done", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(15, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule